// File: doc/BRIEF.md
# Partial Reconfiguration Control Sequencer

This block is a hardware state machine that runs the partial-reconfiguration handshake toward a fabric configuration controller, with no software in the loop. On a start command it first qualifies the request: the controller's mode-select field, its configuration-reset and status pins, and the kind of request (partial or full). It then brings up the configuration path one step at a time. The path is chip-select, the clock/data path and the control overrides. Around the PR request it asks an external clock burst generator for flush bursts.

After that it waits a bounded number of status samples for the ready flag, keeps a streaming window open until the image source signals the end of the image, and waits the same way for the done flag. The shutdown always runs, whatever happened in the waits. When no error came before it, a final health check on three status bits follows.

The result is a 2-bit code that comes with a one-cycle done pulse. The burst generator is reached through a request/acknowledge pair: the request is held with a count until it is acknowledged. The fabric status arrives as one 19-bit vector.

Top module: `prcfg_sequencer`

## Requirements
- R1: At start the mode field stat_i[18:16] must be 3'b000 or 3'b001. Any other value ends the run with result 1, and no control output changes.
- R2: At start stat_i[12] (configuration-reset pin high) and stat_i[4] (status pin high) must both be 1. Otherwise the run ends with result 1 and no control output changes.
- R3: A start with full_cfg_i=1 (full-configuration request) is rejected with result 1, and no control output changes.
- R4: Bring-up happens in this order, one change per step: cs_n_o falls, then path_en_o rises, then ovr_en_o rises, then a burst of FLUSH_CLKS (256), then pr_req_o rises, then a burst of PREP_CLKS (2047). Each burst request is held until burst_ack_i.
- R5: The ready wait samples status up to POLL_TRIES (10) times. stat_i[11] (PR error) is checked first and gives result 1. stat_i[9] (PR ready) moves on to streaming. If neither appears, the result is 2 (timeout).
- R6: stream_en_o is high from a successful ready wait until img_end_i is seen. It is high only while pr_req_o is high.
- R7: The done wait uses stat_i[10] (PR done), with the same try limit and the same error-first rule as R5.
- R8: Shutdown always runs after either wait, in this order: pr_req_o falls, a burst of FLUSH_CLKS, path_en_o falls, cs_n_o rises, ovr_en_o falls. An error from a wait is the reported result.
- R9: With no earlier error, the result is 0 only if stat_i[2] (user mode), stat_i[6] (configuration done) and stat_i[4] are all 1. Otherwise the result is 2.
- R10: result_o codes are 0 success, 1 invalid setup or PR error, and 2 timeout. The code is valid during a one-cycle done_o pulse. After reset and in idle, cs_n_o=1 and all other control outputs are 0.
- R11: A start while a run is in progress is ignored. That run still gives exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command pulse |
| full_cfg_i | input | 1 | 1 = full-configuration request (rejected) |
| img_end_i | input | 1 | Image source has sent the last word |
| stat_i | input | 19 | Fabric status vector |
| burst_ack_i | input | 1 | Burst generator finished the requested clocks |
| burst_req_o | output | 1 | Burst request, held until acknowledged |
| burst_cnt_o | output | CNT_W | Number of clocks requested |
| cs_n_o | output | 1 | Active-low chip-select |
| path_en_o | output | 1 | Configuration clock/data path enable |
| ovr_en_o | output | 1 | Control override enable |
| pr_req_o | output | 1 | PR request |
| stream_en_o | output | 1 | Image streaming window |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Result code |

## Verification
The bench builds the block with its default parameters: ten poll tries, a 12-bit count, and flush and preparation counts of 256 and 2047. These counts only travel to the burst generator model, so full-size values cost no run time. Every run writes the order of control-output changes into a signature. Comparing that signature covers the bring-up order, the shutdown after a failed ready or done wait, and the absence of any change after a rejected start. Each wait is tested with the error flag raised together with the ready flag, and with the awaited flag never arriving.

// File: rtl/prcfg_pkg.sv
package prcfg_pkg;
  localparam int STAT_W    = 19;
  localparam int MODE_LSB  = 16;
  localparam int NCFG_BIT  = 12;
  localparam int PRERR_BIT = 11;
  localparam int PRDON_BIT = 10;
  localparam int PRRDY_BIT = 9;
  localparam int CDONE_BIT = 6;
  localparam int NSTAT_BIT = 4;
  localparam int UMODE_BIT = 2;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_INVAL   = 2'd1,
    RES_TIMEOUT = 2'd2
  } res_e;

  typedef enum logic [4:0] {
    S_IDLE, S_CHECK, S_PATH_ON, S_OVR_ON, S_F1_GO, S_F1_WAIT,
    S_F2_GO, S_F2_WAIT, S_WREADY, S_STREAM, S_WDONE, S_DROP,
    S_F3_GO, S_F3_WAIT, S_CS_OFF, S_OVR_OFF, S_FINAL
  } seq_e;
endpackage

// File: rtl/prcfg_burst.sv
module prcfg_burst #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fin_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= 1'b0;
      cnt_o <= '0;
      fin_o <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go_i) begin
        req_o <= 1'b1;
        cnt_o <= cnt_i;
      end else if (req_o && ack_i) begin
        req_o <= 1'b0;
        fin_o <= 1'b1;
      end
    end
  end

  // R4: a pending request and its count stay put until acknowledged
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i && !go_i) |=> (req_o && $stable(cnt_o)));
endmodule

// File: rtl/prcfg_poll.sv
module prcfg_poll
  import prcfg_pkg::*;
#(
  parameter int TRIES = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_i,
  input  logic       err_i,
  input  logic       hit_i,
  output logic       fin_o,
  output logic [1:0] code_o
);
  localparam int CW = $clog2(TRIES + 1);

  logic          active;
  logic [CW-1:0] tries_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      tries_q <= '0;
      fin_o   <= 1'b0;
      code_o  <= RES_OK;
    end else begin
      fin_o <= 1'b0;
      if (go_i) begin
        active  <= 1'b1;
        tries_q <= '0;
      end else if (active) begin
        if (err_i) begin
          active <= 1'b0;
          fin_o  <= 1'b1;
          code_o <= RES_INVAL;
        end else if (hit_i) begin
          active <= 1'b0;
          fin_o  <= 1'b1;
          code_o <= RES_OK;
        end else if (tries_q == CW'(TRIES - 1)) begin
          active <= 1'b0;
          fin_o  <= 1'b1;
          code_o <= RES_TIMEOUT;
        end else begin
          tries_q <= tries_q + 1'b1;
        end
      end
    end
  end

  // R5/R7: never more samples than the try limit
  assert_poll_bound_R5: assert property (@(posedge clk) disable iff (rst)
    active |-> (tries_q < CW'(TRIES)));
  // R5/R7: error flag wins over the awaited flag
  assert_err_first_R7: assert property (@(posedge clk) disable iff (rst)
    (active && !go_i && err_i) |=> (fin_o && code_o == RES_INVAL));
endmodule

// File: rtl/prcfg_sequencer.sv
module prcfg_sequencer
  import prcfg_pkg::*;
#(
  parameter int POLL_TRIES = 10,
  parameter int CNT_W      = 12,
  parameter int FLUSH_CLKS = 256,
  parameter int PREP_CLKS  = 2047
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              full_cfg_i,
  input  logic              img_end_i,
  input  logic [18:0]       stat_i,
  input  logic              burst_ack_i,
  output logic              burst_req_o,
  output logic [CNT_W-1:0]  burst_cnt_o,
  output logic              cs_n_o,
  output logic              path_en_o,
  output logic              ovr_en_o,
  output logic              pr_req_o,
  output logic              stream_en_o,
  output logic              done_o,
  output logic [1:0]        result_o
);
  seq_e       state_q;
  logic [1:0] err_q;

  logic             burst_go, burst_fin;
  logic [CNT_W-1:0] burst_cnt;
  logic             poll_go, poll_fin, poll_hit;
  logic [1:0]       poll_code;

  logic [2:0] mode;
  logic       setup_ok, health_ok;

  assign mode      = stat_i[MODE_LSB+2:MODE_LSB];
  assign setup_ok  = !full_cfg_i && (mode <= 3'd1) &&
                     stat_i[NCFG_BIT] && stat_i[NSTAT_BIT];
  assign health_ok = stat_i[UMODE_BIT] && stat_i[CDONE_BIT] && stat_i[NSTAT_BIT];

  assign burst_go  = (state_q == S_F1_GO) || (state_q == S_F2_GO) ||
                     (state_q == S_F3_GO);
  assign burst_cnt = (state_q == S_F2_GO) ? CNT_W'(PREP_CLKS) : CNT_W'(FLUSH_CLKS);
  assign poll_go   = ((state_q == S_F2_WAIT) && burst_fin) ||
                     ((state_q == S_STREAM) && img_end_i);
  assign poll_hit  = (state_q == S_WDONE) ? stat_i[PRDON_BIT] : stat_i[PRRDY_BIT];

  prcfg_burst #(.CNT_W(CNT_W)) burst_i (
    .clk(clk), .rst(rst), .go_i(burst_go), .cnt_i(burst_cnt),
    .ack_i(burst_ack_i), .req_o(burst_req_o), .cnt_o(burst_cnt_o),
    .fin_o(burst_fin)
  );

  prcfg_poll #(.TRIES(POLL_TRIES)) poll_i (
    .clk(clk), .rst(rst), .go_i(poll_go), .err_i(stat_i[PRERR_BIT]),
    .hit_i(poll_hit), .fin_o(poll_fin), .code_o(poll_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      err_q       <= RES_OK;
      cs_n_o      <= 1'b1;
      path_en_o   <= 1'b0;
      ovr_en_o    <= 1'b0;
      pr_req_o    <= 1'b0;
      stream_en_o <= 1'b0;
      done_o      <= 1'b0;
      result_o    <= RES_OK;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE:    if (start_i) state_q <= S_CHECK;
        S_CHECK: begin
          err_q <= RES_OK;
          if (setup_ok) begin
            cs_n_o  <= 1'b0;
            state_q <= S_PATH_ON;
          end else begin
            result_o <= RES_INVAL;
            done_o   <= 1'b1;
            state_q  <= S_IDLE;
          end
        end
        S_PATH_ON: begin path_en_o <= 1'b1; state_q <= S_OVR_ON; end
        S_OVR_ON:  begin ovr_en_o  <= 1'b1; state_q <= S_F1_GO;  end
        S_F1_GO:   state_q <= S_F1_WAIT;
        S_F1_WAIT: if (burst_fin) begin pr_req_o <= 1'b1; state_q <= S_F2_GO; end
        S_F2_GO:   state_q <= S_F2_WAIT;
        S_F2_WAIT: if (burst_fin) state_q <= S_WREADY;
        S_WREADY: if (poll_fin) begin
          if (poll_code == RES_OK) begin
            stream_en_o <= 1'b1;
            state_q     <= S_STREAM;
          end else begin
            err_q   <= poll_code;
            state_q <= S_DROP;
          end
        end
        S_STREAM: if (img_end_i) begin stream_en_o <= 1'b0; state_q <= S_WDONE; end
        S_WDONE:  if (poll_fin) begin err_q <= poll_code; state_q <= S_DROP; end
        S_DROP:    begin pr_req_o <= 1'b0; state_q <= S_F3_GO; end
        S_F3_GO:   state_q <= S_F3_WAIT;
        S_F3_WAIT: if (burst_fin) begin path_en_o <= 1'b0; state_q <= S_CS_OFF; end
        S_CS_OFF:  begin cs_n_o   <= 1'b1; state_q <= S_OVR_OFF; end
        S_OVR_OFF: begin ovr_en_o <= 1'b0; state_q <= S_FINAL;   end
        S_FINAL: begin
          if (err_q != RES_OK) result_o <= err_q;
          else                 result_o <= health_ok ? RES_OK : RES_TIMEOUT;
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R4: PR request only with the whole path brought up
  assert_prreq_path_R4: assert property (@(posedge clk) disable iff (rst)
    pr_req_o |-> (!cs_n_o && path_en_o && ovr_en_o));
  // R6: streaming window lies inside the PR request
  assert_stream_in_req_R6: assert property (@(posedge clk) disable iff (rst)
    stream_en_o |-> pr_req_o);
  // R10: done is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R10: idle means every control output released
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> (cs_n_o && !path_en_o && !ovr_en_o && !pr_req_o &&
                             !stream_en_o && !burst_req_o));
  // R1: a bad mode field rejects with result 1 and leaves chip-select high
  assert_bad_mode_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CHECK && mode > 3'd1) |=> (done_o && result_o == RES_INVAL && cs_n_o));
  // R11: a run is only entered from idle
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE) |=> (state_q != S_CHECK));
endmodule

// File: tb/prcfg_sequencer_tb_top.sv
module prcfg_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, full_cfg_i = 1'b0, img_end_i = 1'b0, burst_ack_i = 1'b0;
  logic [18:0] stat_i;
  logic        burst_req_o, cs_n_o, path_en_o, ovr_en_o, pr_req_o, stream_en_o, done_o;
  logic [11:0] burst_cnt_o;
  logic [1:0]  result_o;

  // fabric status model
  logic [2:0] f_mode = 3'd0;
  logic f_ncfg = 1, f_nstat = 1, f_err = 0, f_rdy = 1, f_don = 1, f_cdone = 1, f_user = 1;
  logic err_on_stream = 0, restart_mid = 0;

  assign stat_i = {f_mode, 3'b000, f_ncfg, f_err, f_don, f_rdy, 2'b00,
                   f_cdone, 1'b0, f_nstat, 1'b0, f_user, 2'b00};

  int checks = 0, failures = 0;
  longint ev_sig = 0;
  int done_cnt = 0;

  always #5 clk = ~clk;

  prcfg_sequencer dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .full_cfg_i(full_cfg_i),
    .img_end_i(img_end_i), .stat_i(stat_i), .burst_ack_i(burst_ack_i),
    .burst_req_o(burst_req_o), .burst_cnt_o(burst_cnt_o), .cs_n_o(cs_n_o),
    .path_en_o(path_en_o), .ovr_en_o(ovr_en_o), .pr_req_o(pr_req_o),
    .stream_en_o(stream_en_o), .done_o(done_o), .result_o(result_o)
  );

  // burst generator model
  initial forever begin
    @(negedge clk);
    if (burst_ack_i) burst_ack_i = 1'b0;
    else if (burst_req_o) begin
      repeat (2) @(negedge clk);
      burst_ack_i = 1'b1;
    end
  end

  // image source model
  initial forever begin
    @(negedge clk);
    if (stream_en_o && !img_end_i) begin
      if (err_on_stream) f_err = 1'b1;
      if (restart_mid) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (2) @(negedge clk);
      img_end_i = 1'b1;
      @(negedge clk);
      img_end_i = 1'b0;
    end
  end

  // change logger: one hex digit per event
  initial begin
    logic p_cs = 1, p_path = 0, p_ovr = 0, p_req = 0, p_str = 0, p_br = 0;
    forever begin
      @(negedge clk);
      if (p_cs && !cs_n_o)       ev_sig = ev_sig * 16 + 1;
      if (!p_cs && cs_n_o)       ev_sig = ev_sig * 16 + 12;
      if (!p_path && path_en_o)  ev_sig = ev_sig * 16 + 2;
      if (p_path && !path_en_o)  ev_sig = ev_sig * 16 + 11;
      if (!p_ovr && ovr_en_o)    ev_sig = ev_sig * 16 + 3;
      if (p_ovr && !ovr_en_o)    ev_sig = ev_sig * 16 + 13;
      if (!p_br && burst_req_o)  ev_sig = ev_sig * 16 + ((burst_cnt_o == 12'd256) ? 4 :
                                                         (burst_cnt_o == 12'd2047) ? 6 : 15);
      if (!p_req && pr_req_o)    ev_sig = ev_sig * 16 + 5;
      if (p_req && !pr_req_o)    ev_sig = ev_sig * 16 + 9;
      if (!p_str && stream_en_o) ev_sig = ev_sig * 16 + 7;
      if (p_str && !stream_en_o) ev_sig = ev_sig * 16 + 8;
      if (done_o) done_cnt++;
      p_cs = cs_n_o; p_path = path_en_o; p_ovr = ovr_en_o;
      p_req = pr_req_o; p_str = stream_en_o; p_br = burst_req_o;
    end
  end

  localparam longint SIG_FULL  = 64'h123456789_4BCD;
  localparam longint SIG_NOSTR = 64'h1234569_4BCD;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_nominal();
    f_mode = 3'd0; f_ncfg = 1; f_nstat = 1; f_err = 0; f_rdy = 1; f_don = 1;
    f_cdone = 1; f_user = 1; full_cfg_i = 0; err_on_stream = 0; restart_mid = 0;
  endtask

  task automatic run_once(output logic [1:0] code);
    int cyc = 0;
    ev_sig = 0; done_cnt = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (!done_o && cyc < 5000) begin @(negedge clk); cyc++; end
    if (cyc >= 5000) begin
      failures++;
      $display("FAIL run watchdog actual=hung expected=done");
    end
    code = result_o;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 reset cs_n", cs_n_o, 1);
    chk("R10 reset ctl", {path_en_o, ovr_en_o, pr_req_o, stream_en_o, burst_req_o, done_o}, 0);
  endtask

  task automatic t_pass();
    logic [1:0] c;
    set_nominal(); run_once(c);
    chk("R10 pass code", c, 0);
    chk("R4 R6 R8 order", ev_sig, SIG_FULL);
    f_mode = 3'd1; run_once(c);
    chk("R1 mode 001 accepted", c, 0);
  endtask

  task automatic t_reject();
    logic [1:0] c;
    set_nominal(); f_mode = 3'd2; run_once(c);
    chk("R1 mode 010 code", c, 1); chk("R1 no change", ev_sig, 0);
    set_nominal(); f_mode = 3'd7; run_once(c);
    chk("R1 mode 111 code", c, 1);
    set_nominal(); f_ncfg = 0; run_once(c);
    chk("R2 cfg pin low", c, 1); chk("R2 no change", ev_sig, 0);
    set_nominal(); f_nstat = 0; run_once(c);
    chk("R2 status pin low", c, 1);
    set_nominal(); full_cfg_i = 1; run_once(c);
    chk("R3 full config", c, 1); chk("R3 no change", ev_sig, 0);
  endtask

  task automatic t_ready_wait();
    logic [1:0] c;
    set_nominal(); f_err = 1; run_once(c);
    chk("R5 error before ready", c, 1); chk("R8 shutdown after ready err", ev_sig, SIG_NOSTR);
    set_nominal(); f_rdy = 0; run_once(c);
    chk("R5 ready timeout", c, 2); chk("R8 shutdown after timeout", ev_sig, SIG_NOSTR);
  endtask

  task automatic t_done_wait();
    logic [1:0] c;
    set_nominal(); err_on_stream = 1; run_once(c);
    chk("R7 error in done wait", c, 1); chk("R8 shutdown after done err", ev_sig, SIG_FULL);
    set_nominal(); f_don = 0; run_once(c);
    chk("R7 done timeout", c, 2); chk("R8 earlier error kept", ev_sig, SIG_FULL);
  endtask

  task automatic t_final();
    logic [1:0] c;
    set_nominal(); f_user = 0; run_once(c);
    chk("R9 user mode low", c, 2);
    set_nominal(); f_cdone = 0; run_once(c);
    chk("R9 config done low", c, 2);
  endtask

  task automatic t_restart();
    logic [1:0] c;
    set_nominal(); restart_mid = 1; run_once(c);
    chk("R11 busy start code", c, 0);
    chk("R11 single done", done_cnt, 1);
    chk("R11 no second run", ev_sig, SIG_FULL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pass();
    t_reject();
    t_ready_wait();
    t_done_wait();
    t_final();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL global watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule